// File: doc/BRIEF.md
# Dual-Register Sum-of-Products Logic Cell

This block is one output cell of a sum-of-products programmable array. A configuration word chooses which literals feed each product term. The literals are the global array inputs, the cell's two register outputs and the value seen at its pin, each in true and complemented form. Twelve logic product terms form three sums of four terms each. Mode bits can fold the second and third sums into the first, which gives one function of up to twelve terms.

Two registers are always available. Register A takes the folded function and register B takes the second sum. Each register has an input polarity bit. Each register is clocked by its own product term and cleared asynchronously by its own product term. A shared bank preset input, a preload path and a power-up clear complete the register controls.

A fifth control product term drives the pin's output enable. A selector puts one of four sources on the pin: the folded combinational function, either register, or the third sum. Both register states are brought out for test observation.

Top module: `pld_macrocell`

## Requirements
- R1: Literal index i is arr_in[i] for i < NIN, register A at NIN, register B at NIN+1 and pin_in at NIN+2, for NLIT = NIN+3 literals. Product term p takes cfg bits [p*2*NLIT +: 2*NLIT]. The low NLIT bits select literals in true form and the high NLIT bits select them complemented. The term is the AND of the selected literals, and a term with nothing selected is 1.
- R2: Terms 0..4*... are grouped by PTS: sum s is the OR of terms s*PTS .. s*PTS+PTS-1, for s = 0, 1, 2. With MB = (3*PTS+5)*2*NLIT, the folded function is sum0 OR (cfg[MB+2] AND sum1) OR (cfg[MB+3] AND sum2).
- R3: The pin source is chosen by cfg[MB+5:MB+4]: 0 gives the folded function, 1 gives register A, 2 gives register B and 3 gives sum2.
- R4: The D input of register A is the folded function XOR cfg[MB]. The D input of register B is sum1 XOR cfg[MB+1].
- R5: Register A loads on a rising edge of term 3*PTS. Register B loads on a rising edge of term 3*PTS+1.
- R6: Term 3*PTS+2 clears register A at once, and term 3*PTS+3 clears register B at once. A clear overrides every other control.
- R7: When bank_set is high and there is no clear and no preload, a clock edge sets the register to 1 instead of loading D.
- R8: When pl_en is high and there is no clear, a clock edge loads pl_d[0] into register A or pl_d[1] into register B. Preload takes priority over preset.
- R9: While por_n is low, both registers are held at 0.
- R10: pin_oe equals term 3*PTS+4. The pin literal is taken from pin_in, the externally resolved pad value.
- R11: q_obs[0] shows register A and q_obs[1] shows register B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arr_in | input | NIN | Global array inputs |
| cfg | input | CFGW | Term masks followed by six mode bits |
| bank_set | input | 1 | Shared synchronous preset |
| pl_en | input | 1 | Preload enable |
| pl_d | input | 2 | Preload values for register B and register A |
| por_n | input | 1 | Power-up clear, active low |
| pin_in | input | 1 | Resolved pad value fed back to the array |
| pin_out | output | 1 | Value driven toward the pad |
| pin_oe | output | 1 | Pad output enable |
| q_obs | output | 2 | Observed register states |

## Verification
The bench uses NIN = 8 and PTS = 4, so the configuration word is 380 bits. Every pin-source setting, both polarity bits and all four fold combinations are reached within four configurations. Array input 0 carries the bench clock, which drives both clock terms. In two of the configurations register B's clock term is gated by input 1, so the two registers load on different edges. Sparse random masks produce empty terms and terms that read the register and pin feedback literals. The clear terms are formed from data literals, so clears collide with clock edges, preloads and presets.

// File: rtl/pld_macrocell.sv
module pld_macrocell #(
  parameter int NIN = 8,
  parameter int PTS = 4,
  localparam int NLIT = NIN + 3,
  localparam int PTW = 2 * NLIT,
  localparam int NL = 3 * PTS,
  localparam int NPT = NL + 5,
  localparam int MB = NPT * PTW,
  localparam int CFGW = MB + 6
) (
  input  logic [NIN-1:0]  arr_in,
  input  logic [CFGW-1:0] cfg,
  input  logic            bank_set,
  input  logic            pl_en,
  input  logic [1:0]      pl_d,
  input  logic            por_n,
  input  logic            pin_in,
  output logic            pin_out,
  output logic            pin_oe,
  output logic [1:0]      q_obs
);
  logic [NLIT-1:0] lit;
  logic [NPT-1:0]  pt;
  logic [2:0]      sm;
  logic [1:0]      q, d, ck_pt, clr;
  logic            f0;

  assign lit = {pin_in, q, arr_in};

  for (genvar p = 0; p < NPT; p++) begin : g_pt
    assign pt[p] = (&(~cfg[p*PTW +: NLIT] | lit)) & (&(~cfg[p*PTW+NLIT +: NLIT] | ~lit));
  end

  for (genvar s = 0; s < 3; s++) begin : g_sum
    assign sm[s] = |pt[s*PTS +: PTS];
  end

  assign f0    = sm[0] | (cfg[MB+2] & sm[1]) | (cfg[MB+3] & sm[2]);
  assign d     = {sm[1], f0} ^ cfg[MB+1:MB];
  assign ck_pt = pt[NL+1:NL];
  assign clr   = pt[NL+3:NL+2] | {2{~por_n}};

  for (genvar g = 0; g < 2; g++) begin : g_ff
    logic r;
    always_ff @(posedge ck_pt[g] or posedge clr[g]) begin
      if (clr[g])        r <= 1'b0;
      else if (pl_en)    r <= pl_d[g];
      else if (bank_set) r <= 1'b1;
      else               r <= d[g];
    end
    assign q[g] = r;
  end

  always_comb begin
    case (cfg[MB+5:MB+4])
      2'd0:    pin_out = f0;
      2'd1:    pin_out = q[0];
      2'd2:    pin_out = q[1];
      default: pin_out = sm[2];
    endcase
  end

  assign pin_oe = pt[NL+4];
  assign q_obs  = q;
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk (
  input logic       por_n,
  input logic       bank_set,
  input logic       pl_en,
  input logic [1:0] pl_d,
  input logic [1:0] q,
  input logic [1:0] ckpt,
  input logic [1:0] clr
);
  always @(negedge ckpt[0]) begin
    if (!por_n) assert_por_clear_R9: assert (q == 2'b00);
  end

  for (genvar g = 0; g < 2; g++) begin : g_ck
    assert_async_clear_R6: assert property (@(negedge ckpt[g]) disable iff (!por_n)
      clr[g] |-> q[g] == 1'b0);
    assert_preload_R8: assert property (@(negedge ckpt[g]) disable iff (!por_n)
      (pl_en && !clr[g]) |-> q[g] == pl_d[g]);
    assert_bank_set_R7: assert property (@(negedge ckpt[g]) disable iff (!por_n)
      (bank_set && !pl_en && !clr[g]) |-> q[g] == 1'b1);
  end
endmodule

bind pld_macrocell pld_macrocell_chk u_chk (
  .por_n(por_n), .bank_set(bank_set), .pl_en(pl_en), .pl_d(pl_d),
  .q(q_obs), .ckpt(ck_pt), .clr(clr)
);

// File: tb/sim_pld_macrocell.sv
module sim_pld_macrocell;
  localparam int NIN = 8, PTS = 4;
  localparam int NLIT = NIN + 3, PTW = 2 * NLIT, NL = 3 * PTS;
  localparam int NPT = NL + 5, MB = NPT * PTW, CFGW = MB + 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [NIN-1:1] din;
  logic [NIN-1:0] arr_in;
  logic [CFGW-1:0] cfg;
  logic bank_set, pl_en, por_n, pin_in;
  logic [1:0] pl_d, q_obs, mq;
  logic pin_out, pin_oe;
  string tag0, tag1;
  int checks = 0, fails = 0;

  assign arr_in = {din, clk};

  pld_macrocell #(.NIN(NIN), .PTS(PTS)) u0 (
    .arr_in(arr_in), .cfg(cfg), .bank_set(bank_set), .pl_en(pl_en), .pl_d(pl_d),
    .por_n(por_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .q_obs(q_obs));

  function automatic logic [NLIT-1:0] lits();
    return {pin_in, mq, din, 1'b0};
  endfunction

  function automatic logic ptv(int p, logic [NLIT-1:0] l);
    for (int i = 0; i < NLIT; i++) begin
      if (cfg[p*PTW+i] && !l[i]) return 1'b0;
      if (cfg[p*PTW+NLIT+i] && l[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic sumv(int s, logic [NLIT-1:0] l);
    logic r = 1'b0;
    for (int k = 0; k < PTS; k++) r |= ptv(s*PTS+k, l);
    return r;
  endfunction

  function automatic logic fold(logic [NLIT-1:0] l);
    return sumv(0, l) || (cfg[MB+2] && sumv(1, l)) || (cfg[MB+3] && sumv(2, l));
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic mkcfg(int osel, int inv, int mab, int mc, int gate);
    cfg = '0;
    for (int p = 0; p < NL; p++) begin
      int n = $urandom % 3;
      for (int k = 0; k < n; k++) begin
        int idx = 1 + ($urandom % (NLIT - 1));
        cfg[p*PTW + idx + (($urandom % 2) ? NLIT : 0)] = 1'b1;
      end
    end
    cfg[NL*PTW] = 1'b1;
    cfg[(NL+1)*PTW] = 1'b1;
    if (gate != 0) cfg[(NL+1)*PTW + 1] = 1'b1;
    cfg[(NL+2)*PTW + 5] = 1'b1; cfg[(NL+2)*PTW + 6] = 1'b1; cfg[(NL+2)*PTW + 7] = 1'b1;
    cfg[(NL+3)*PTW + 6] = 1'b1; cfg[(NL+3)*PTW + 7] = 1'b1; cfg[(NL+3)*PTW + NLIT + 4] = 1'b1;
    cfg[(NL+4)*PTW + 2 + ($urandom % 6) + (($urandom % 2) ? NLIT : 0)] = 1'b1;
    cfg[MB+1:MB] = inv[1:0];
    cfg[MB+2] = mab[0];
    cfg[MB+3] = mc[0];
    cfg[MB+5:MB+4] = osel[1:0];
  endtask

  task automatic compare();
    logic [NLIT-1:0] l = lits();
    logic exp;
    check({tag0, " regA"}, q_obs[0], mq[0]);
    check({tag1, " regB"}, q_obs[1], mq[1]);
    check("R10 pin_oe", pin_oe, ptv(NL+4, l));
    case (cfg[MB+5:MB+4])
      2'd0: begin exp = fold(l); check("R2 R1 pin_out fold", pin_out, exp); end
      2'd1: check("R3 pin_out regA", pin_out, mq[0]);
      2'd2: check("R3 pin_out regB", pin_out, mq[1]);
      default: begin exp = sumv(2, l); check("R3 R1 pin_out sum2", pin_out, exp); end
    endcase
  endtask

  task automatic model_edge();
    logic [NLIT-1:0] l = lits();
    logic [1:0] dv, clrv, ckv;
    dv[0] = fold(l) ^ cfg[MB];
    dv[1] = sumv(1, l) ^ cfg[MB+1];
    ckv[0] = 1'b1;
    ckv[1] = !cfg[(NL+1)*PTW + 1] || din[1];
    clrv[0] = !por_n || ptv(NL+2, l);
    clrv[1] = !por_n || ptv(NL+3, l);
    for (int g = 0; g < 2; g++) begin
      string t;
      logic nv;
      if (clrv[g]) begin nv = 1'b0; t = por_n ? "R6" : "R9"; end
      else if (!ckv[g]) begin nv = mq[g]; t = "R5 hold"; end
      else if (pl_en) begin nv = pl_d[g]; t = "R8 R11"; end
      else if (bank_set) begin nv = 1'b1; t = "R7 R11"; end
      else begin nv = dv[g]; t = "R5 R4 R11"; end
      mq[g] = nv;
      if (g == 0) tag0 = t; else tag1 = t;
    end
  endtask

  task automatic drive_and_clear();
    logic [NLIT-1:0] l;
    din = NIN'($urandom) >> 1;
    bank_set = ($urandom % 8) == 0;
    pl_en = ($urandom % 10) == 0;
    pl_d = 2'($urandom);
    pin_in = 1'($urandom);
    por_n = ($urandom % 50) != 0;
    #1;
    l = lits();
    if (!por_n || ptv(NL+2, l)) begin mq[0] = 1'b0; tag0 = por_n ? "R6" : "R9"; end
    if (!por_n || ptv(NL+3, l)) begin mq[1] = 1'b0; tag1 = por_n ? "R6" : "R9"; end
  endtask

  task automatic run_phase(int osel, int inv, int mab, int mc, int gate, int n);
    @(negedge clk); #1;
    mkcfg(osel, inv, mab, mc, gate);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      #1;
      compare();
      drive_and_clear();
    end
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    mq = 2'b00; tag0 = "R9"; tag1 = "R9";
    din = '0; bank_set = 0; pl_en = 0; pl_d = 0; pin_in = 0; por_n = 0;
    mkcfg(0, 0, 1, 1, 0);
    repeat (3) @(negedge clk);
    #1;
    check("R9 reset regA", q_obs[0], 1'b0);
    check("R9 reset regB", q_obs[1], 1'b0);
    por_n = 1;
    run_phase(0, 0, 1, 1, 0, 400);
    run_phase(1, 1, 0, 1, 1, 400);
    run_phase(2, 2, 1, 0, 1, 400);
    run_phase(3, 3, 0, 0, 0, 400);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule